// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Receiver

This block receives asynchronous serial frames on a single line for use on a shared multidrop bus. It finds each start bit, recovers eight data bits (least significant first), an optional ninth bit, and one stop bit. It then moves the finished word into a one-entry holding register, where the host reads it. The ninth bit separates address words (ninth bit 1) from data words (ninth bit 0). A node that is waiting to be addressed turns on address filtering. Data words then disappear before they reach the holding register. Once the node sees its own address, the host turns filtering off and receives the data words that follow.

Timing comes from an external oversampling strobe that pulses sixteen times per bit period. The block has no baud generator of its own. Start bits are qualified at mid-bit. Every later bit is decided by a two-of-three vote of samples taken around the bit centre. Status outputs report a framing fault on the most recently stored word and an overrun that freezes reception. An interrupt request is gated by three separate enable levels.

Top module: `mdrop_uart_rx`

## Requirements
- R1: While reset is asserted and right after it, rx_data, rx_bit8, rx_ready, frame_err, overrun_err and irq are all 0.
- R2: With nine_bit_en=0, a frame consists of a low start bit, eight data bits sent LSB first, and a stop bit. On completion, rx_data holds the byte, rx_bit8 reads 0 and rx_ready is 1.
- R3: With nine_bit_en=1 and addr_det_en=0, a ninth bit follows data bit 7 and is stored in rx_bit8. Every word is stored, whether its ninth bit is 0 or 1.
- R4: With nine_bit_en=1 and addr_det_en=1, a word whose ninth bit is 0 leaves rx_data, rx_bit8 and rx_ready unchanged. A word whose ninth bit is 1 is stored and sets rx_ready.
- R5: With nine_bit_en=0, addr_det_en has no effect, and every eight-bit word is stored.
- R6: A one-cycle pulse on rd_strobe clears rx_ready and leaves rx_data unchanged.
- R7: A stored word whose stop bit samples low sets frame_err to 1, and the word is still stored. The next word stored with a high stop bit clears frame_err.
- R8: A word that completes while rx_ready is 1 (and no read arrives in that cycle) sets overrun_err and is discarded. While overrun_err is 1, no frame is received. Driving cont_rx_en low clears overrun_err.
- R9: A low pulse on rx_in shorter than half a bit period does not start a frame.
- R10: Each bit after the start bit is the majority of three samples at ticks 7, 8 and 9 of the bit. One corrupted sample does not change the bit.
- R11: irq equals rx_ready AND irq_rx_en AND irq_periph_en AND irq_global_en.
- R12: While serial_en=0 or cont_rx_en=0, frames on rx_in are not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_en | input | 1 | Serial port enable |
| nine_bit_en | input | 1 | Frames carry a ninth bit |
| cont_rx_en | input | 1 | Continuous receive enable; low clears overrun |
| addr_det_en | input | 1 | Drop words whose ninth bit is 0 |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rd_strobe | input | 1 | Host read of the holding register |
| rx_in | input | 1 | Serial line, idle high |
| irq_rx_en | input | 1 | Receive interrupt enable |
| irq_periph_en | input | 1 | Peripheral interrupt enable |
| irq_global_en | input | 1 | Global interrupt enable |
| rx_data | output | 8 | Stored data byte |
| rx_bit8 | output | 1 | Stored ninth bit |
| rx_ready | output | 1 | Holding register holds an unread word |
| frame_err | output | 1 | Stop bit of stored word sampled low |
| overrun_err | output | 1 | Word lost because the register was full |
| irq | output | 1 | Interrupt request |

## Verification
The overrun-and-halt state is the hardest to reach from the ports. The bench gets there with two back-to-back complete frames and no read between them. It then sends a third frame and checks that the held data does not change, and toggles cont_rx_en to confirm that reception resumes. The vote logic is tested with a frame where every data bit carries a four-clock inverted spike near its centre. Because the strobe runs every four clocks, such a spike can corrupt only one of the three samples. The address filter is tested by sending a data word with filtering on and checking that the previously stored byte is still there.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       bit8;
    logic       ferr;
  } rx_word_t;
endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign dout = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/mdrop_rx_engine.sv
module mdrop_rx_engine
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     nine_bit_en,
  input  logic     tick,
  input  logic     rx,
  input  logic     fall,
  output logic     word_valid,
  output rx_word_t word
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] C_SA   = CW'(MID - 1);
  localparam logic [CW-1:0] C_SB   = CW'(MID);
  localparam logic [CW-1:0] C_VOTE = CW'(MID + 1);
  localparam logic [CW-1:0] C_END  = CW'(OSR - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    idx_q, idx_d;
  logic          done_d, done_q;
  logic          smp_a_q, smp_b_q;
  logic [8:0]    shreg_q;
  logic          ferr_q;
  logic          vote;
  logic [3:0]    last_idx;

  assign vote     = (smp_a_q & smp_b_q) | (smp_a_q & rx) | (smp_b_q & rx);
  assign last_idx = nine_bit_en ? 4'd8 : 4'd7;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    if (!run) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      idx_d   = '0;
    end else if (state_q == ST_IDLE) begin
      if (fall) begin
        state_d = ST_START;
        cnt_d   = '0;
      end
    end else if (tick) begin
      cnt_d = (cnt_q == C_END) ? '0 : cnt_q + 1'b1;
      if (cnt_q == C_VOTE) begin
        if (state_q == ST_START && vote) state_d = ST_IDLE;
        if (state_q == ST_STOP) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      if (cnt_q == C_END) begin
        if (state_q == ST_START) begin
          state_d = ST_DATA;
          idx_d   = '0;
        end else if (state_q == ST_DATA) begin
          if (idx_q == last_idx) state_d = ST_STOP;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
      shreg_q <= '0;
      ferr_q  <= 1'b0;
    end else if (tick && state_q != ST_IDLE && run) begin
      if (cnt_q == C_SA) smp_a_q <= rx;
      if (cnt_q == C_SB) smp_b_q <= rx;
      if (cnt_q == C_VOTE && state_q == ST_DATA) shreg_q[idx_q] <= vote;
      if (cnt_q == C_VOTE && state_q == ST_STOP) ferr_q <= ~vote;
    end
  end

  assign word_valid = done_q;
  assign word.data  = shreg_q[7:0];
  assign word.bit8  = nine_bit_en & shreg_q[8];
  assign word.ferr  = ferr_q;

  assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (state_q == ST_IDLE && !word_valid));
endmodule

// File: rtl/mdrop_rx_buffer.sv
module mdrop_rx_buffer
  import mdrop_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_valid,
  input  rx_word_t   word,
  input  logic       nine_bit_en,
  input  logic       addr_det_en,
  input  logic       cont_rx_en,
  input  logic       rd_strobe,
  output logic [7:0] data,
  output logic       bit8,
  output logic       ready,
  output logic       ferr,
  output logic       ovr
);
  logic       accept, load, lose;
  logic       ready_d, ovr_d;

  assign accept = word_valid & ~(nine_bit_en & addr_det_en & ~word.bit8);
  assign load   = accept & (~ready | rd_strobe);
  assign lose   = accept & ready & ~rd_strobe;

  always_comb begin
    ready_d = ready;
    ovr_d   = ovr;
    if (rd_strobe) ready_d = 1'b0;
    if (load)      ready_d = 1'b1;
    if (lose)      ovr_d   = 1'b1;
    if (!cont_rx_en) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      ready <= ready_d;
      ovr   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      bit8 <= 1'b0;
      ferr <= 1'b0;
    end else if (load) begin
      data <= word.data;
      bit8 <= word.bit8;
      ferr <= word.ferr;
    end
  end

  assert_drop_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && nine_bit_en && addr_det_en && !word.bit8 && !rd_strobe)
      |=> ($stable(data) && $stable(ready)));

  assert_overrun_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && ready && !rd_strobe && cont_rx_en)
      |=> (ovr && $stable(data)));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !word_valid) |=> !ready);
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_en,
  input  logic       nine_bit_en,
  input  logic       cont_rx_en,
  input  logic       addr_det_en,
  input  logic       baud_tick,
  input  logic       rd_strobe,
  input  logic       rx_in,
  input  logic       irq_rx_en,
  input  logic       irq_periph_en,
  input  logic       irq_global_en,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_ready,
  output logic       frame_err,
  output logic       overrun_err,
  output logic       irq
);
  logic     rx_s, rx_fall, run, word_valid;
  rx_word_t word;

  assign run = serial_en & cont_rx_en & ~overrun_err;

  mdrop_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s), .fall(rx_fall)
  );

  mdrop_rx_engine #(.OSR(OSR)) u_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .nine_bit_en(nine_bit_en),
    .tick(baud_tick), .rx(rx_s), .fall(rx_fall),
    .word_valid(word_valid), .word(word)
  );

  mdrop_rx_buffer u_buffer (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
    .nine_bit_en(nine_bit_en), .addr_det_en(addr_det_en),
    .cont_rx_en(cont_rx_en), .rd_strobe(rd_strobe),
    .data(rx_data), .bit8(rx_bit8), .ready(rx_ready),
    .ferr(frame_err), .ovr(overrun_err)
  );

  assign irq = rx_ready & irq_rx_en & irq_periph_en & irq_global_en;

  assert_halt_on_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |-> !word_valid);

  assert_irq_needs_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (rx_ready && irq_global_en));
endmodule

// File: tb/tb_mdrop_uart_rx.sv
module tb_mdrop_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serial_en = 1'b0, nine_bit_en = 1'b0, cont_rx_en = 1'b0, addr_det_en = 1'b0;
  logic       baud_tick = 1'b0, rd_strobe = 1'b0, rx_in = 1'b1;
  logic       irq_rx_en = 1'b0, irq_periph_en = 1'b0, irq_global_en = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_ready, frame_err, overrun_err, irq;
  int         checks = 0, failures = 0;
  logic [1:0] tdiv = 2'd0;

  mdrop_uart_rx dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic lvl, input logic spike);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rx_in = (spike && i >= 30 && i < 34) ? ~lvl : lvl;
    end
  endtask

  task automatic send_frame(input logic [8:0] w, input logic nine,
                            input logic stop_lvl, input logic spike);
    send_bit(1'b0, 1'b0);
    for (int b = 0; b < 8; b++) send_bit(w[b], spike);
    if (nine) send_bit(w[8], spike);
    send_bit(stop_lvl, 1'b0);
    send_bit(1'b1, 1'b0);
    @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 data", {8'h0, rx_data}, 16'h0);
    chk("R1 flags", {11'h0, rx_bit8, rx_ready, frame_err, overrun_err, irq}, 16'h0);
  endtask

  task automatic t_eight_bit();
    nine_bit_en = 1'b0; addr_det_en = 1'b0;
    send_frame(9'h0A5, 1'b0, 1'b1, 1'b0);
    chk("R2 data", {8'h0, rx_data}, 16'h00A5);
    chk("R2 bit8/ready", {14'h0, rx_bit8, rx_ready}, 16'h1);
    do_read();
    chk("R6 ready cleared", {15'h0, rx_ready}, 16'h0);
    chk("R6 data kept", {8'h0, rx_data}, 16'h00A5);
  endtask

  task automatic t_nine_no_filter();
    nine_bit_en = 1'b1; addr_det_en = 1'b0;
    send_frame(9'h03C, 1'b1, 1'b1, 1'b0);
    chk("R3 data word", {7'h0, rx_bit8, rx_data}, 16'h003C);
    do_read();
    send_frame(9'h1C3, 1'b1, 1'b1, 1'b0);
    chk("R3 address word", {7'h0, rx_bit8, rx_data}, 16'h01C3);
    chk("R3 ready", {15'h0, rx_ready}, 16'h1);
    do_read();
  endtask

  task automatic t_filter();
    nine_bit_en = 1'b1; addr_det_en = 1'b1;
    send_frame(9'h011, 1'b1, 1'b1, 1'b0);
    chk("R4 dropped ready", {15'h0, rx_ready}, 16'h0);
    chk("R4 dropped data", {7'h0, rx_bit8, rx_data}, 16'h01C3);
    send_frame(9'h142, 1'b1, 1'b1, 1'b0);
    chk("R4 address stored", {7'h0, rx_bit8, rx_data}, 16'h0142);
    chk("R4 ready", {15'h0, rx_ready}, 16'h1);
    do_read();
    nine_bit_en = 1'b0;
    send_frame(9'h066, 1'b0, 1'b1, 1'b0);
    chk("R5 eight-bit with filter", {7'h0, rx_bit8, rx_data}, 16'h0066);
    chk("R5 ready", {15'h0, rx_ready}, 16'h1);
    do_read();
    addr_det_en = 1'b0;
  endtask

  task automatic t_irq();
    send_frame(9'h081, 1'b0, 1'b1, 1'b0);
    irq_rx_en = 1'b1; irq_periph_en = 1'b1; irq_global_en = 1'b1;
    #1 chk("R11 irq all enabled", {15'h0, irq}, 16'h1);
    irq_periph_en = 1'b0;
    #1 chk("R11 irq one disabled", {15'h0, irq}, 16'h0);
    irq_periph_en = 1'b1;
    do_read();
    #1 chk("R11 irq after read", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_framing();
    send_frame(9'h05A, 1'b0, 1'b0, 1'b0);
    chk("R7 ferr set, word stored", {7'h0, frame_err, rx_data}, 16'h015A);
    do_read();
    send_frame(9'h0A0, 1'b0, 1'b1, 1'b0);
    chk("R7 ferr cleared", {7'h0, frame_err, rx_data}, 16'h00A0);
    do_read();
  endtask

  task automatic t_overrun();
    send_frame(9'h012, 1'b0, 1'b1, 1'b0);
    send_frame(9'h034, 1'b0, 1'b1, 1'b0);
    chk("R8 overrun set", {15'h0, overrun_err}, 16'h1);
    chk("R8 second discarded", {8'h0, rx_data}, 16'h0012);
    do_read();
    send_frame(9'h056, 1'b0, 1'b1, 1'b0);
    chk("R8 halted", {7'h0, rx_ready, rx_data}, 16'h0012);
    @(negedge clk) cont_rx_en = 1'b0;
    @(negedge clk) cont_rx_en = 1'b1;
    @(negedge clk);
    chk("R8 overrun cleared", {15'h0, overrun_err}, 16'h0);
    send_frame(9'h078, 1'b0, 1'b1, 1'b0);
    chk("R8 resumed", {7'h0, rx_ready, rx_data}, 16'h0178);
    do_read();
  endtask

  task automatic t_glitch();
    @(negedge clk) rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (900) @(negedge clk);
    chk("R9 short pulse ignored", {15'h0, rx_ready}, 16'h0);
    send_frame(9'h0C7, 1'b0, 1'b1, 1'b0);
    chk("R9 next frame intact", {7'h0, rx_ready, rx_data}, 16'h01C7);
    do_read();
  endtask

  task automatic t_majority();
    send_frame(9'h0B4, 1'b0, 1'b1, 1'b1);
    chk("R10 spikes voted out", {7'h0, rx_ready, rx_data}, 16'h01B4);
    do_read();
  endtask

  task automatic t_disabled();
    serial_en = 1'b0;
    send_frame(9'h0EE, 1'b0, 1'b1, 1'b0);
    chk("R12 serial_en off", {15'h0, rx_ready}, 16'h0);
    serial_en = 1'b1; cont_rx_en = 1'b0;
    send_frame(9'h0EE, 1'b0, 1'b1, 1'b0);
    chk("R12 cont_rx_en off", {7'h0, rx_ready, rx_data}, 16'h00B4);
    cont_rx_en = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    serial_en = 1'b1; cont_rx_en = 1'b1;
    repeat (20) @(negedge clk);
    t_eight_bit();
    t_nine_no_filter();
    t_filter();
    t_irq();
    t_framing();
    t_overrun();
    t_glitch();
    t_majority();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule